// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block sits between a request source and a byte-level I2C master engine. It takes one SMBus-style request (target address, direction, command code, protocol kind, block length) and turns it into the ordered series of engine commands it needs: START, address and command bytes, an optional repeated START, data bytes and a closing STOP. It then finishes with a single result code. After each command it waits for one status event from the engine. The event is byte-done, negative acknowledge, or bus error, and it is sampled together with the engine's bus-ownership level.

Payload bytes move through a byte-wide buffer port. Outgoing bytes are read at `buf_raddr`, and incoming bytes are written through `buf_we`/`buf_waddr`/`buf_wdata`. For reads, the acknowledge control toward the engine is armed one byte before the final byte, so that the engine NACKs the last byte. A missing device, a bus fault and a silent engine each end the request in their own way. A bus fault or a silent engine also raises a one-cycle request for an engine reset.

Top module: `smb_txn_seq`

## Requirements
- R1: The address byte is the 7-bit target address shifted left by one with the direction in bit 0 (1 = read). Kinds byte-data (2), word (3) and block (4) send the address with bit 0 forced to 0 and then the command code. A read then issues a repeated START together with the address byte with bit 0 = 1. Kinds quick (0) and byte (1) send the address byte straight after the START.
- R2: A request is taken only when `busy` is low. Taking it pulses `eng_start` and raises `busy`. A `req_valid` pulse while busy is ignored and produces no extra bytes or completion.
- R3: Transfer length is 0 for quick, 1 for byte and byte-data, 2 for word (buffer index 0 first, low byte) and `req_len` for block. A byte-kind write sends the command code as its single data byte.
- R4: In the write phase, each byte-done event sends the buffer byte at the next index. The event after the last data byte pulses `eng_stop` and completes with result OK (0).
- R5: In the read phase, each byte-done event stores `rx_byte` at the next buffer index. `eng_ack` is high while the last byte is received and low for earlier bytes. After the last byte the block pulses `eng_stop` and completes with OK.
- R6: A negative acknowledge in any phase pulses `eng_stop` and `eng_nack_clr` and completes with result NODEV (1), with `reset_req` low.
- R7: A bus error, or `ev_master` low at an event, completes with result IOERR (2) and `reset_req` high and issues no STOP. This takes priority over a NACK in the same cycle.
- R8: If no status event arrives for `TMO_CYC` consecutive cycles while busy, the block completes with IOERR and `reset_req` high. An event in the expiring cycle is served instead.
- R9: A read of zero length, a block length of 0 or above `MAX_LEN`, or an unknown kind completes with INVAL (3) in the cycle after the request, with no START.
- R10: `done` is a one-cycle pulse that carries `result` and `reset_req`, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 7 | Target address |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_cmd | input | 8 | Command code |
| req_kind | input | 3 | 0 quick, 1 byte, 2 byte-data, 3 word, 4 block |
| req_len | input | LEN_W (6) | Block length |
| busy | output | 1 | Request in progress |
| eng_start | output | 1 | START / repeated START pulse |
| eng_stop | output | 1 | STOP pulse |
| eng_tx_valid | output | 1 | Byte to send is valid |
| eng_tx_byte | output | 8 | Byte to send |
| eng_ack | output | 1 | Acknowledge control level for reception |
| eng_nack_clr | output | 1 | Clear NACK/stall status pulse |
| ev_done | input | 1 | Byte-done event |
| ev_nack | input | 1 | Negative acknowledge event |
| ev_berr | input | 1 | Bus error event |
| ev_master | input | 1 | Engine owns the bus (level) |
| rx_byte | input | 8 | Received byte, valid with ev_done |
| buf_raddr | output | IDX_W (5) | Buffer read index |
| buf_rdata | input | 8 | Buffer read data at buf_raddr |
| buf_we | output | 1 | Buffer write strobe |
| buf_waddr | output | IDX_W (5) | Buffer write index |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | Completion pulse |
| result | output | 2 | 0 OK, 1 NODEV, 2 IOERR, 3 INVAL |
| reset_req | output | 1 | Engine reset request, valid with done |

## Verification
The silence timeout and the arrival of a status event can fall in the same cycle. The bench stalls the engine model and counts cycles from acceptance. It raises byte-done exactly in the cycle the timer would expire. The check passes only if that cycle yields the next address byte and no completion, and if a full timeout window later the request ends in IOERR with a reset request. A NACK and a bus error raised together in one event are also provoked, and the result must be IOERR with no STOP.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

  typedef enum logic [2:0] {
    K_QUICK = 3'd0,
    K_BYTE  = 3'd1,
    K_BDATA = 3'd2,
    K_WORD  = 3'd3,
    K_BLOCK = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_NODEV = 2'd1,
    RES_IOERR = 2'd2,
    RES_INVAL = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CMD,
    S_RSTART,
    S_QUICK,
    S_READ,
    S_WRITE
  } state_e;

endpackage

// File: rtl/smb_req_decode.sv
module smb_req_decode
  import smb_seq_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6
) (
  input  logic [2:0]       kind,
  input  logic             rd,
  input  logic [LEN_W-1:0] blk_len,
  output logic [LEN_W-1:0] xfer_len,
  output logic             bad,
  output logic             short_form,
  output logic             cmd_as_data
);

  always_comb begin
    xfer_len    = '0;
    bad         = 1'b0;
    short_form  = 1'b0;
    cmd_as_data = 1'b0;
    case (kind_e'(kind))
      K_QUICK: short_form = 1'b1;
      K_BYTE: begin
        short_form  = 1'b1;
        xfer_len    = LEN_W'(1);
        cmd_as_data = !rd;
      end
      K_BDATA: xfer_len = LEN_W'(1);
      K_WORD:  xfer_len = LEN_W'(2);
      K_BLOCK: begin
        xfer_len = blk_len;
        bad      = (blk_len == '0) || (blk_len > LEN_W'(MAX_LEN));
      end
      default: bad = 1'b1;
    endcase
    if (rd && xfer_len == '0) bad = 1'b1;
  end

endmodule

// File: rtl/smb_evt_timer.sv
module smb_evt_timer #(
  parameter int TMO_CYC = 10_000_000,
  parameter int CNT_W   = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expire
);

  logic [CNT_W-1:0] cnt;

  assign expire = run && !restart && (cnt == CNT_W'(TMO_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt <= '0;
    else if (!expire)           cnt <= cnt + CNT_W'(1);
  end

  // R8: the silence counter never passes the window
  a_r8_window_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= CNT_W'(TMO_CYC - 1)));

endmodule

// File: rtl/smb_phase_fsm.sv
module smb_phase_fsm
  import smb_seq_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             reject,
  input  logic             evt,
  input  logic             expire,
  input  logic             ev_nack,
  input  logic             ev_berr,
  input  logic             ev_master,
  input  logic [7:0]       rx_byte,
  input  logic [6:0]       req_addr,
  input  logic             req_rd,
  input  logic [7:0]       req_cmd,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             short_form,
  input  logic             cmd_as_data,
  input  logic [7:0]       buf_rdata,
  output logic             busy,
  output logic             eng_start,
  output logic             eng_stop,
  output logic             eng_tx_valid,
  output logic [7:0]       eng_tx_byte,
  output logic             eng_ack,
  output logic             eng_nack_clr,
  output logic [IDX_W-1:0] buf_raddr,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_waddr,
  output logic [7:0]       buf_wdata,
  output logic             done,
  output logic [1:0]       result,
  output logic             reset_req
);

  state_e           st;
  logic [7:0]       adr_q;
  logic [7:0]       cmd_q;
  logic [LEN_W-1:0] rem_q;
  logic [IDX_W-1:0] idx_q;
  logic             cad_q;

  assign busy      = (st != S_IDLE);
  assign buf_raddr = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      adr_q        <= '0;
      cmd_q        <= '0;
      rem_q        <= '0;
      idx_q        <= '0;
      cad_q        <= 1'b0;
      eng_start    <= 1'b0;
      eng_stop     <= 1'b0;
      eng_tx_valid <= 1'b0;
      eng_tx_byte  <= '0;
      eng_ack      <= 1'b0;
      eng_nack_clr <= 1'b0;
      buf_we       <= 1'b0;
      buf_waddr    <= '0;
      buf_wdata    <= '0;
      done         <= 1'b0;
      result       <= RES_OK;
      reset_req    <= 1'b0;
    end else begin
      eng_start    <= 1'b0;
      eng_stop     <= 1'b0;
      eng_tx_valid <= 1'b0;
      eng_nack_clr <= 1'b0;
      buf_we       <= 1'b0;
      done         <= 1'b0;
      reset_req    <= 1'b0;
      if (st == S_IDLE) begin
        if (reject) begin
          done   <= 1'b1;
          result <= RES_INVAL;
        end else if (take) begin
          adr_q     <= {req_addr, req_rd};
          cmd_q     <= req_cmd;
          rem_q     <= xfer_len;
          idx_q     <= '0;
          cad_q     <= cmd_as_data;
          eng_ack   <= 1'b0;
          eng_start <= 1'b1;
          st        <= short_form ? S_QUICK : S_ADDR;
        end
      end else if (evt) begin
        if (ev_berr || !ev_master) begin
          done      <= 1'b1;
          result    <= RES_IOERR;
          reset_req <= 1'b1;
          st        <= S_IDLE;
        end else if (ev_nack) begin
          eng_stop     <= 1'b1;
          eng_nack_clr <= 1'b1;
          done         <= 1'b1;
          result       <= RES_NODEV;
          st           <= S_IDLE;
        end else begin
          case (st)
            S_ADDR: begin
              eng_tx_valid <= 1'b1;
              eng_tx_byte  <= {adr_q[7:1], 1'b0};
              st           <= S_CMD;
            end
            S_CMD: begin
              eng_tx_valid <= 1'b1;
              eng_tx_byte  <= cmd_q;
              st           <= adr_q[0] ? S_RSTART : S_WRITE;
            end
            S_RSTART, S_QUICK: begin
              if (st == S_RSTART) eng_start <= 1'b1;
              eng_tx_valid <= 1'b1;
              eng_tx_byte  <= adr_q;
              if (adr_q[0]) begin
                eng_ack <= (rem_q == LEN_W'(1));
                st      <= S_READ;
              end else begin
                st      <= S_WRITE;
              end
            end
            S_READ: begin
              eng_ack   <= (rem_q == LEN_W'(2));
              buf_we    <= 1'b1;
              buf_waddr <= idx_q;
              buf_wdata <= rx_byte;
              idx_q     <= idx_q + IDX_W'(1);
              rem_q     <= rem_q - LEN_W'(1);
              if (rem_q == LEN_W'(1)) begin
                eng_stop <= 1'b1;
                done     <= 1'b1;
                result   <= RES_OK;
                st       <= S_IDLE;
              end
            end
            S_WRITE: begin
              if (rem_q == '0) begin
                eng_stop <= 1'b1;
                done     <= 1'b1;
                result   <= RES_OK;
                st       <= S_IDLE;
              end else begin
                eng_tx_valid <= 1'b1;
                eng_tx_byte  <= cad_q ? cmd_q : buf_rdata;
                idx_q        <= idx_q + IDX_W'(1);
                rem_q        <= rem_q - LEN_W'(1);
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end else if (expire) begin
        done      <= 1'b1;
        result    <= RES_IOERR;
        reset_req <= 1'b1;
        st        <= S_IDLE;
      end
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: no request is in flight when completion is reported
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6: a missing device never asks for an engine reset
  a_r6_nodev_quiet: assert property (@(posedge clk) disable iff (rst)
    (done && result == RES_NODEV) |-> !reset_req);

  // R7: faults always ask for a reset and never close with STOP
  a_r7_fault_reset: assert property (@(posedge clk) disable iff (rst)
    (done && result == RES_IOERR) |-> (reset_req && !eng_stop));

  // R2: entering a request always begins with START
  a_r2_start_on_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> eng_start);

  // R9: a rejected request never touches the bus
  a_r9_reject_silent: assert property (@(posedge clk) disable iff (rst)
    (done && result == RES_INVAL) |-> (!eng_start && !eng_tx_valid));

  // R4: STOP is issued on its own
  a_r4_stop_alone: assert property (@(posedge clk) disable iff (rst)
    eng_stop |-> (!eng_tx_valid && !eng_start));

  // R5: received bytes are stored only while a request was active
  a_r5_store_in_flight: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(busy));

endmodule

// File: rtl/smb_txn_seq.sv
module smb_txn_seq #(
  parameter  int MAX_LEN = 32,
  parameter  int TMO_CYC = 10_000_000,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int CNT_W   = $clog2(TMO_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [6:0]       req_addr,
  input  logic             req_rd,
  input  logic [7:0]       req_cmd,
  input  logic [2:0]       req_kind,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             eng_start,
  output logic             eng_stop,
  output logic             eng_tx_valid,
  output logic [7:0]       eng_tx_byte,
  output logic             eng_ack,
  output logic             eng_nack_clr,
  input  logic             ev_done,
  input  logic             ev_nack,
  input  logic             ev_berr,
  input  logic             ev_master,
  input  logic [7:0]       rx_byte,
  output logic [IDX_W-1:0] buf_raddr,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_waddr,
  output logic [7:0]       buf_wdata,
  output logic             done,
  output logic [1:0]       result,
  output logic             reset_req
);

  logic [LEN_W-1:0] xfer_len;
  logic             bad, short_form, cmd_as_data;
  logic             take, reject, evt, expire;

  assign take   = req_valid && !busy && !bad;
  assign reject = req_valid && !busy && bad;
  assign evt    = busy && (ev_done || ev_nack || ev_berr);

  smb_req_decode #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_dec (
    .kind        (req_kind),
    .rd          (req_rd),
    .blk_len     (req_len),
    .xfer_len    (xfer_len),
    .bad         (bad),
    .short_form  (short_form),
    .cmd_as_data (cmd_as_data)
  );

  smb_evt_timer #(.TMO_CYC(TMO_CYC), .CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .restart (take || evt),
    .expire  (expire)
  );

  smb_phase_fsm #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .take         (take),
    .reject       (reject),
    .evt          (evt),
    .expire       (expire),
    .ev_nack      (ev_nack),
    .ev_berr      (ev_berr),
    .ev_master    (ev_master),
    .rx_byte      (rx_byte),
    .req_addr     (req_addr),
    .req_rd       (req_rd),
    .req_cmd      (req_cmd),
    .xfer_len     (xfer_len),
    .short_form   (short_form),
    .cmd_as_data  (cmd_as_data),
    .buf_rdata    (buf_rdata),
    .busy         (busy),
    .eng_start    (eng_start),
    .eng_stop     (eng_stop),
    .eng_tx_valid (eng_tx_valid),
    .eng_tx_byte  (eng_tx_byte),
    .eng_ack      (eng_ack),
    .eng_nack_clr (eng_nack_clr),
    .buf_raddr    (buf_raddr),
    .buf_we       (buf_we),
    .buf_waddr    (buf_waddr),
    .buf_wdata    (buf_wdata),
    .done         (done),
    .result       (result),
    .reset_req    (reset_req)
  );

endmodule

// File: tb/smb_txn_seq_test.sv
module smb_txn_seq_test;
  localparam int MAXL = 32;
  localparam int TMO  = 40;
  localparam int LW   = 6;
  localparam int IW   = 5;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 1'b0, req_rd = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_cmd = '0;
  logic [2:0] req_kind = '0;
  logic [LW-1:0] req_len = '0;
  logic ev_done = 1'b0, ev_nack = 1'b0, ev_berr = 1'b0, ev_master = 1'b1;
  logic [7:0] rx_byte = '0;
  logic busy, eng_start, eng_stop, eng_tx_valid, eng_ack, eng_nack_clr;
  logic [7:0] eng_tx_byte, buf_rdata, buf_wdata;
  logic [IW-1:0] buf_raddr, buf_waddr;
  logic buf_we, done, reset_req;
  logic [1:0] result;

  smb_txn_seq #(.MAX_LEN(MAXL), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_rd(req_rd), .req_cmd(req_cmd), .req_kind(req_kind), .req_len(req_len),
    .busy(busy), .eng_start(eng_start), .eng_stop(eng_stop),
    .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte), .eng_ack(eng_ack),
    .eng_nack_clr(eng_nack_clr), .ev_done(ev_done), .ev_nack(ev_nack),
    .ev_berr(ev_berr), .ev_master(ev_master), .rx_byte(rx_byte),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .buf_we(buf_we),
    .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .done(done),
    .result(result), .reset_req(reset_req)
  );

  logic [7:0] mem [MAXL];
  assign buf_rdata = mem[buf_raddr];
  always @(posedge clk) if (buf_we) mem[buf_waddr] <= buf_wdata;

  int n_chk = 0, n_bad = 0;
  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rxv(int j);
    return 8'(j * 29 + 51);
  endfunction

  // scoreboard queues
  logic [7:0] tx_q[$];
  int res_q[$];
  int done_cnt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (eng_tx_valid) begin
        if (tx_q.size() == 0) chk("R1", "unexpected tx byte", int'(eng_tx_byte), 256);
        else chk("R1", "tx byte", int'(eng_tx_byte), int'(tx_q.pop_front()));
      end
      if (done) begin
        if (res_q.size() == 0) chk("R10", "unexpected done", 1, 0);
        else chk("R10", "result/reset", int'({result, reset_req}), res_q.pop_front());
        done_cnt++;
      end
    end
  end

  // engine model
  bit eng_on = 1'b0, reading = 1'b0, after_start = 1'b0, stop_seen = 1'b0;
  int timer = -1, evn = 0, rd_j = 0, cur_len = 0, inj_at = -1, inj_ty = 0;

  always @(negedge clk) begin
    if (rst || !eng_on) begin
      timer = -1; reading = 1'b0; after_start = 1'b0;
    end else begin
      ev_done = 1'b0; ev_nack = 1'b0; ev_berr = 1'b0; ev_master = 1'b1;
      if (eng_stop) begin
        stop_seen = 1'b1; reading = 1'b0; timer = -1;
      end else if (eng_start || eng_tx_valid) begin
        if (eng_tx_valid) begin
          reading = eng_tx_byte[0] && (eng_start || after_start);
          rd_j = 0;
        end
        after_start = eng_start && !eng_tx_valid;
        timer = LAT;
      end else if (timer > 0) begin
        timer--;
        if (timer == 0) begin
          timer = -1;
          if (evn == inj_at) begin
            case (inj_ty)
              1: ev_nack = 1'b1;
              2: ev_berr = 1'b1;
              3: begin ev_done = 1'b1; ev_master = 1'b0; end
              default: begin ev_nack = 1'b1; ev_berr = 1'b1; end
            endcase
          end else begin
            ev_done = 1'b1;
            if (reading) begin
              rx_byte = rxv(rd_j);
              chk("R5", "ack armed only for last byte", int'(eng_ack), int'(rd_j == cur_len - 1));
              rd_j++;
              timer = LAT;
            end
          end
          evn++;
        end
      end
    end
  end

  task automatic run(string tag, int kind, int rd, int addr, int cmd, int len,
                     int inj_e, int inj_t, int exp_res, int exp_rst, int exp_stop,
                     bit intrude);
    logic [7:0] q[$];
    int d0, wait_n;
    cur_len = (kind == 1 || kind == 2) ? 1 : (kind == 3) ? 2 : (kind == 4) ? len : 0;
    if (exp_res != 3) begin
      if (kind <= 1) begin
        q.push_back({7'(addr), 1'(rd)});
        if (rd == 0 && kind == 1) q.push_back(8'(cmd));
      end else begin
        q.push_back({7'(addr), 1'b0});
        q.push_back(8'(cmd));
        if (rd != 0) q.push_back({7'(addr), 1'b1});
        else for (int i = 0; i < cur_len; i++) q.push_back(mem[i]);
      end
      if (inj_e >= 0) while (q.size() > inj_e) void'(q.pop_back());
    end
    foreach (q[i]) tx_q.push_back(q[i]);
    res_q.push_back(exp_res * 2 + exp_rst);
    evn = 0; stop_seen = 1'b0; inj_at = inj_e; inj_ty = inj_t;
    d0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'(kind); req_rd = 1'(rd);
    req_addr = 7'(addr); req_cmd = 8'(cmd); req_len = LW'(len);
    @(negedge clk); #1;
    req_valid = 1'b0;
    if (exp_res == 3) chk("R9", "reject in next cycle", int'(done && !busy), 1);
    wait_n = 0;
    while (done_cnt == d0 && wait_n < 3000) begin
      @(negedge clk); #1;
      wait_n++;
      if (intrude && wait_n == 4) begin
        req_valid = 1'b1; req_kind = 3'd0; req_rd = 1'b0; req_addr = 7'h7F;
      end else req_valid = 1'b0;
    end
    chk(tag, "completion seen", int'(done_cnt != d0), 1);
    repeat (6) @(negedge clk);
    #1;
    chk("R2", "exactly one completion", done_cnt - d0, 1);
    chk(tag, "all expected bytes sent", tx_q.size(), 0);
    if (eng_on) chk(tag, "STOP issued", int'(stop_seen), exp_stop);
    if (rd != 0 && exp_res == 0)
      for (int j = 0; j < cur_len; j++) chk("R5", "stored byte", int'(mem[j]), int'(rxv(j)));
  endtask

  task automatic silent_req(bit collide);
    int k, d0;
    eng_on = 1'b0;
    d0 = done_cnt;
    if (collide) tx_q.push_back(8'h22);
    res_q.push_back(2 * 2 + 1);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd2; req_rd = 1'b0; req_addr = 7'h11; req_cmd = 8'h04;
    @(negedge clk); #1;
    req_valid = 1'b0;
    k = 1;
    while (done_cnt == d0 && k < 400) begin
      @(negedge clk);
      k++;
      if (collide && k == TMO) begin ev_done = 1'b1; ev_master = 1'b1; end
      if (collide && k == TMO + 1) begin
        ev_done = 1'b0;
        #1;
        chk("R8", "event on expiring cycle is served", int'(done), 0);
      end
      #1;
    end
    if (collide) chk("R8", "second window expires", k, 2 * TMO + 1);
    else         chk("R8", "timeout cycle", k, TMO + 1);
    chk("R8", "tx bytes left", tx_q.size(), 0);
    eng_on = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAXL; i++) mem[i] = 8'(i * 13 + 7);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk("R10", "reset busy", int'(busy), 0);
    chk("R10", "reset done", int'(done), 0);
    chk("R5", "reset ack", int'(eng_ack), 0);
    chk("R2", "reset start", int'(eng_start), 0);
    eng_on = 1'b1;
    //   tag  kind rd addr  cmd  len inj  ty res rst stop intrude
    run("R1", 0, 0, 'h50, 'h00, 0, -1, 0, 0, 0, 1, 0);  // quick write
    run("R3", 1, 0, 'h3C, 'h5A, 0, -1, 0, 0, 0, 1, 0);  // byte write sends cmd
    run("R3", 1, 1, 'h21, 'h00, 0, -1, 0, 0, 0, 1, 0);  // byte read
    run("R4", 2, 0, 'h10, 'h07, 0, -1, 0, 0, 0, 1, 0);  // byte-data write
    run("R5", 3, 1, 'h48, 'h02, 0, -1, 0, 0, 0, 1, 0);  // word read, low first
    run("R4", 4, 0, 'h2A, 'h80, 5, -1, 0, 0, 0, 1, 0);  // block write
    run("R5", 4, 1, 'h6E, 'h11, 32, -1, 0, 0, 0, 1, 0); // block read max
    run("R6", 2, 0, 'h10, 'h07, 0, 1, 1, 1, 0, 1, 0);   // NACK on address
    run("R7", 3, 0, 'h48, 'h02, 0, 2, 2, 2, 1, 0, 0);   // bus error
    run("R7", 4, 1, 'h6E, 'h11, 4, 0, 3, 2, 1, 0, 0);   // lost mastership
    run("R7", 2, 0, 'h10, 'h07, 0, 1, 4, 2, 1, 0, 0);   // NACK + bus error
    run("R9", 0, 1, 'h50, 'h00, 0, -1, 0, 3, 0, 0, 0);  // zero-length read
    run("R9", 4, 0, 'h50, 'h00, 0, -1, 0, 3, 0, 0, 0);  // block len 0
    run("R9", 4, 1, 'h50, 'h00, 33, -1, 0, 3, 0, 0, 0); // block len too big
    run("R9", 6, 0, 'h50, 'h00, 1, -1, 0, 3, 0, 0, 0);  // unknown kind
    run("R2", 4, 0, 'h33, 'h09, 4, -1, 0, 0, 0, 1, 1);  // request while busy
    silent_req(1'b0);
    silent_req(1'b1);
    run("R1", 1, 0, 'h3C, 'h5A, 0, -1, 0, 0, 0, 1, 0);  // recovers after timeouts
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule